// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable logic cell of a larger fabric. It takes an 18-bit input vector, forms 23 product terms from it and drives four data outputs and one output enable. Each product term is an AND over any chosen subset of the inputs, each input taken true or complemented. Twenty of the terms feed the four output sum stages. The remaining three are control terms: a register clear, a register clock and an output enable toward the I/O cells.

Each output picks between two sum paths. The narrow path is the OR of the four terms that belong to that output. The wide path is the OR of any mask of the twenty sum terms, passed through an XOR stage. Each output also picks whether it is taken straight from its sum or from a register behind it. The registers capture on the global clock or, when `clk_sel` is high, on rising edges of the clock product term. Configuration words are written through a parallel port: one address per product term row and one per output. The global reset clears both the configuration and the registers.

Top module: `glb_cell`

## Requirements
- R1: While `rst_n` is low and afterwards until configuration is written, `dout` and `oe` are 0 for every input value. Reset clears all configuration, and a term with no selected input evaluates to 0.
- R2: Input i of a product term is set by row bits [2i+1:2i]. 2'b01 uses the input true, 2'b10 uses it complemented and 2'b00 ignores it. 2'b11 forces the term to 0. A row with no input selected gives 0.
- R3: On the narrow path (mode bit 22 = 0), output k is the OR of product terms 4k to 4k+3, with no XOR.
- R4: On the wide path (bit 22 = 1), output k is the OR of sum terms 0..19 selected by mask bits [19:0], XORed with an operand chosen by bits [21:20]. 00 gives 0, 01 gives constant 1, 10 gives term 4k and 11 gives 0.
- R5: With bit 23 = 0 an output is combinational: `dout` follows `din` with no clock edge.
- R6: With bit 23 = 1 and `clk_sel` = 0, an output shows the sum value captured at the last rising `clk` edge.
- R7: With `clk_sel` = 1, the registers capture only at edges where the clock term (row 21) is 1 and was 0 at the previous edge. At all other edges they hold.
- R8: When the clear term (row 20) is 1 at an edge, every register is 0 after that edge, whatever the capture condition. Low `rst_n` clears the registers and the configuration at once, without a clock edge.
- R9: `oe` equals the value of the output-enable term (row 22) at all times.
- R10: With `cfg_we` high, address 0..22 loads `cfg_data` into that product term row. Address 23+k loads `cfg_data[23:0]` as the mode word of output k, laid out as {registered[23], wide[22], xor select[21:20], mask[19:0]}. Addresses 27..31 change nothing. A write takes effect after the edge that samples it.
- R11: At an edge where `cfg_we` is high and the clear term is 0, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_sel | input | 1 | 0: registers use the global clock; 1: registers capture on rising clock term |
| din | input | 18 | Logic inputs |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Row or mode word address |
| cfg_data | input | 36 | Configuration data |
| dout | output | 4 | Data outputs |
| oe | output | 1 | Output enable from the enable term |

## Verification
The checker watches the register behaviour on every cycle. It checks that a clear term empties the registers at the next edge and that a write cycle freezes them. It checks that a low clock term in clock-term mode blocks capture, and that global-clock mode captures the sum. It also checks that an empty row yields a 0 term and that mode words land where they are addressed. The AND/OR/XOR function itself is shown only by the bench's input patterns. Those scenarios also cover the operand choices of the XOR stage, the forcing code 2'b11, the ignored addresses and the rising-edge rule of the clock term, which needs a sequence of input values to exercise.

// File: rtl/glb_pkg.sv
package glb_pkg;
  localparam int NUM_IN     = 18;
  localparam int NUM_OUT    = 4;
  localparam int PT_PER_OUT = 4;
  localparam int NUM_SUM_PT = 20;
  localparam int NUM_PT     = NUM_SUM_PT + 3;
  localparam int PT_RST     = NUM_SUM_PT;
  localparam int PT_CLK     = NUM_SUM_PT + 1;
  localparam int PT_OE      = NUM_SUM_PT + 2;
  localparam int PT_W       = 2 * NUM_IN;
  localparam int OCFG_W     = NUM_SUM_PT + 4;
  localparam int ADDR_W     = $clog2(NUM_PT + NUM_OUT);

  typedef enum logic [1:0] {
    XOR_NONE = 2'b00,
    XOR_ONE  = 2'b01,
    XOR_PT   = 2'b10,
    XOR_RSV  = 2'b11
  } xsel_e;

  typedef struct packed {
    logic                  reg_mode;
    logic                  wide;
    logic [1:0]            xsel;
    logic [NUM_SUM_PT-1:0] mask;
  } ocfg_t;
endpackage

// File: rtl/glb_cfg_store.sv
module glb_cfg_store
  import glb_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [PT_W-1:0]                cfg_data,
  output logic [NUM_PT-1:0][PT_W-1:0]    pt_cfg,
  output ocfg_t [NUM_OUT-1:0]            ocfg
);
  logic [NUM_PT-1:0][PT_W-1:0] pt_nxt;
  ocfg_t [NUM_OUT-1:0]         oc_nxt;

  always_comb begin
    pt_nxt = pt_cfg;
    oc_nxt = ocfg;
    for (int r = 0; r < NUM_PT; r++) begin
      if (cfg_addr == ADDR_W'(r)) pt_nxt[r] = cfg_data;
    end
    for (int k = 0; k < NUM_OUT; k++) begin
      if (cfg_addr == ADDR_W'(NUM_PT + k)) oc_nxt[k] = cfg_data[OCFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_cfg <= '0;
      ocfg   <= '0;
    end else if (cfg_we) begin
      pt_cfg <= pt_nxt;
      ocfg   <= oc_nxt;
    end
  end
endmodule

// File: rtl/glb_pt_array.sv
module glb_pt_array
  import glb_pkg::*;
(
  input  logic [NUM_IN-1:0]            din,
  input  logic [NUM_PT-1:0][PT_W-1:0]  pt_cfg,
  output logic [NUM_PT-1:0]            pt
);
  for (genvar j = 0; j < NUM_PT; j++) begin : g_term
    logic [NUM_IN-1:0] used;
    logic [NUM_IN-1:0] hit;
    always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
        used[i] = pt_cfg[j][2*i] | pt_cfg[j][2*i+1];
        hit[i]  = (pt_cfg[j][2*i] ? din[i] : 1'b1) &
                  (pt_cfg[j][2*i+1] ? ~din[i] : 1'b1);
      end
    end
    assign pt[j] = (|used) & (&hit);
  end
endmodule

// File: rtl/glb_sum.sv
module glb_sum
  import glb_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [NUM_SUM_PT-1:0] pt_sum,
  input  ocfg_t                 cfg,
  output logic                  sum
);
  localparam int BASE = IDX * PT_PER_OUT;

  logic narrow;
  logic wide_or;
  logic xop;

  always_comb begin
    narrow  = |pt_sum[BASE +: PT_PER_OUT];
    wide_or = |(pt_sum & cfg.mask);
    case (xsel_e'(cfg.xsel))
      XOR_ONE: xop = 1'b1;
      XOR_PT:  xop = pt_sum[BASE];
      default: xop = 1'b0;
    endcase
    sum = cfg.wide ? (wide_or ^ xop) : narrow;
  end
endmodule

// File: rtl/glb_out_reg.sv
module glb_out_reg
  import glb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_sel,
  input  logic               cfg_we,
  input  logic               pt_rst,
  input  logic               pt_clk,
  input  logic [NUM_OUT-1:0] sum,
  output logic [NUM_OUT-1:0] q
);
  logic               pt_clk_q;
  logic               cap;
  logic               en;
  logic [NUM_OUT-1:0] d;

  always_comb begin
    cap = clk_sel ? (pt_clk & ~pt_clk_q) : 1'b1;
    en  = pt_rst | (~cfg_we & cap);
    d   = pt_rst ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_clk_q <= 1'b0;
      q        <= '0;
    end else begin
      pt_clk_q <= pt_clk;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/glb_cell.sv
module glb_cell
  import glb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_sel,
  input  logic [NUM_IN-1:0]    din,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [PT_W-1:0]      cfg_data,
  output logic [NUM_OUT-1:0]   dout,
  output logic                 oe
);
  logic                        rst_meta;
  logic                        rst_int;
  logic [NUM_PT-1:0][PT_W-1:0] pt_cfg;
  ocfg_t [NUM_OUT-1:0]         ocfg;
  logic [NUM_PT-1:0]           pt_vec;
  logic [NUM_OUT-1:0]          sum_vec;
  logic [NUM_OUT-1:0]          q_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  glb_cfg_store u_cfg (
    .clk      (clk),
    .rst_n    (rst_int),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .pt_cfg   (pt_cfg),
    .ocfg     (ocfg)
  );

  glb_pt_array u_and (
    .din    (din),
    .pt_cfg (pt_cfg),
    .pt     (pt_vec)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    glb_sum #(.IDX(k)) u_sum (
      .pt_sum (pt_vec[NUM_SUM_PT-1:0]),
      .cfg    (ocfg[k]),
      .sum    (sum_vec[k])
    );
    assign dout[k] = ocfg[k].reg_mode ? q_vec[k] : sum_vec[k];
  end

  glb_out_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_int),
    .clk_sel (clk_sel),
    .cfg_we  (cfg_we),
    .pt_rst  (pt_vec[PT_RST]),
    .pt_clk  (pt_vec[PT_CLK]),
    .sum     (sum_vec),
    .q       (q_vec)
  );

  assign oe = pt_vec[PT_OE];
endmodule

// File: rtl/glb_cell_chk.sv
module glb_cell_chk
  import glb_pkg::*;
(
  input logic                               clk,
  input logic                               rst_int,
  input logic                               clk_sel,
  input logic                               cfg_we,
  input logic [ADDR_W-1:0]                  cfg_addr,
  input logic [PT_W-1:0]                    cfg_data,
  input logic [NUM_PT-1:0]                  pt,
  input logic [NUM_PT-1:0][PT_W-1:0]        pt_cfg,
  input logic [NUM_OUT-1:0][OCFG_W-1:0]     ocfg,
  input logic [NUM_OUT-1:0]                 sum,
  input logic [NUM_OUT-1:0]                 q
);
  assert_term_clear_R8: assert property (@(posedge clk) disable iff (!rst_int)
    $past(pt[PT_RST]) |-> (q == '0));

  assert_write_hold_R11: assert property (@(posedge clk) disable iff (!rst_int)
    ($past(rst_int) && $past(cfg_we) && !$past(pt[PT_RST])) |-> (q == $past(q)));

  assert_term_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_int)
    ($past(rst_int) && $past(clk_sel) && !$past(pt[PT_CLK]) && !$past(pt[PT_RST]))
    |-> (q == $past(q)));

  assert_global_capture_R6: assert property (@(posedge clk) disable iff (!rst_int)
    ($past(rst_int) && !$past(clk_sel) && !$past(cfg_we) && !$past(pt[PT_RST]))
    |-> (q == $past(sum)));

  for (genvar j = 0; j < NUM_PT; j++) begin : g_empty
    assert_empty_term_R2: assert property (@(posedge clk) disable iff (!rst_int)
      (pt_cfg[j] == '0) |-> !pt[j]);
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_mode
    assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rst_int)
      ($past(rst_int) && $past(cfg_we) && ($past(cfg_addr) == ADDR_W'(NUM_PT + k)))
      |-> (ocfg[k] == $past(cfg_data[OCFG_W-1:0])));
  end
endmodule

bind glb_cell glb_cell_chk u_chk (
  .clk      (clk),
  .rst_int  (rst_int),
  .clk_sel  (clk_sel),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_data (cfg_data),
  .pt       (pt_vec),
  .pt_cfg   (pt_cfg),
  .ocfg     (ocfg),
  .sum      (sum_vec),
  .q        (q_vec)
);

// File: tb/glb_cell_tb.sv
`timescale 1ns/1ps
module glb_cell_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_sel;
  logic [17:0] din;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [35:0] cfg_data;
  logic [3:0]  dout;
  logic        oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  glb_cell u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .din      (din),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .dout     (dout),
    .oe       (oe)
  );

  // {din, expected dout[3:0], expected oe}; outputs 0..2 narrow, output 3 wide inverted
  localparam logic [22:0] VECS [0:7] = '{
    {18'h00000, 4'b1001, 1'b0},
    {18'h00007, 4'b0001, 1'b0},
    {18'h00004, 4'b1000, 1'b0},
    {18'h0000C, 4'b1010, 1'b0},
    {18'h2000C, 4'b1000, 1'b0},
    {18'h10024, 4'b0000, 1'b1},
    {18'h00014, 4'b1000, 1'b0},
    {18'h3FFFF, 4'b0001, 1'b1}
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [35:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_sel = 1'b0; din = 18'h3FFFF;
    cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    repeat (3) tick();
    #1 check("R1 reset state", {dout, oe}, 5'b0);
    tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R2 R3 R4 R9 R10 configuration
    wr(5'd0,  36'h000000005);
    wr(5'd1,  36'h000000020);
    wr(5'd4,  36'h800000040);
    wr(5'd8,  36'h000000300);
    wr(5'd12, 36'h000000400);
    wr(5'd22, 36'h100000000);
    wr(5'd26, 36'h000501001);

    // R2 R3 R4 R5 R9 combinational table
    for (int v = 0; v < 8; v++) begin
      din = VECS[v][22:5];
      #1 check("R5 R3 R4 R2 R9 table", {dout, oe}, VECS[v][4:0]);
      tick();
    end

    // R4 XOR with term 12
    wr(5'd26, 36'h000600001);
    din = 18'h00003; #1 check("R4 xor term", {4'b0, dout[3]}, 5'd1);
    din = 18'h00023; #1 check("R4 xor term", {4'b0, dout[3]}, 5'd0);
    din = 18'h00020; #1 check("R4 xor term", {4'b0, dout[3]}, 5'd1);
    tick();

    // R10 ignored addresses
    din = 18'h00000;
    wr(5'd27, {36{1'b1}});
    wr(5'd31, {36{1'b1}});
    #1 check("R10 ignored address", {dout, oe}, 5'b00010);
    tick();

    // R6 registered on global clock
    wr(5'd23, 36'h000800000);
    din = 18'h00004; tick();
    #1 check("R6 capture 0", {4'b0, dout[0]}, 5'd0);
    din = 18'h00007;
    #1 check("R6 no change before edge", {4'b0, dout[0]}, 5'd0);
    tick();
    #1 check("R6 capture 1", {4'b0, dout[0]}, 5'd1);

    // R11 hold during write
    din = 18'h00004; cfg_we = 1'b1; cfg_addr = 5'd27; cfg_data = '0;
    tick();
    #1 check("R11 hold in write", {4'b0, dout[0]}, 5'd1);
    cfg_we = 1'b0;
    tick();
    #1 check("R11 capture after write", {4'b0, dout[0]}, 5'd0);

    // R7 clock term on input 15
    wr(5'd21, 36'h040000000);
    clk_sel = 1'b1;
    din = 18'h00004; tick();
    din = 18'h00007; tick();
    #1 check("R7 no rise", {4'b0, dout[0]}, 5'd0);
    din = 18'h08007; tick();
    #1 check("R7 rise captures", {4'b0, dout[0]}, 5'd1);
    din = 18'h08004; tick();
    #1 check("R7 level high holds", {4'b0, dout[0]}, 5'd1);
    din = 18'h00004; tick();
    #1 check("R7 fall holds", {4'b0, dout[0]}, 5'd1);
    din = 18'h08004; tick();
    #1 check("R7 second rise", {4'b0, dout[0]}, 5'd0);

    // R8 clear term on input 14, then global reset
    clk_sel = 1'b0;
    wr(5'd20, 36'h010000000);
    din = 18'h00007; tick();
    #1 check("R8 before clear", {4'b0, dout[0]}, 5'd1);
    din = 18'h04007; tick();
    #1 check("R8 term clear", {4'b0, dout[0]}, 5'd0);
    din = 18'h00007; tick();
    #1 check("R8 after clear", {4'b0, dout[0]}, 5'd1);
    rst_n = 1'b0;
    #1 check("R8 async reset", {dout, oe}, 5'b0);
    din = 18'h3FFFF;
    #1 check("R1 config cleared", {dout, oe}, 5'b0);
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule